// File: doc/BRIEF.md
# SPI Status, Error and Interrupt Unit

This unit holds the flag state of an SPI controller. It sits between the serial shift engine and the register bus. The shift engine reports three kinds of event: a transmit word taken into the shifter, a received word, and the received CRC word. The bus side reports accesses to the data, status and first control register. From these the unit keeps the transmit-empty, receive-not-empty and busy flags and the one-word receive buffer. It also detects three errors: a mode fault, a receive overrun and a CRC mismatch.

The unit owns the controller's enable and master bits. A mode fault arises when the controller is master and the slave-select input says another master is driving the bus. The fault drops both bits at once and then locks them. The lock lifts only after a status access followed by a write to the first control register. Each flag has its own clear rule. A single interrupt line combines the flags with three enables.

Top module: `spi_stat_unit`

## Requirements
- R1: After reset, txe is 1. spi_en, mst_mode, rxne, busy, mfault, ovr, crcerr and irq are 0, and rx_buf is all zeros.
- R2: A data write clears txe and an engine transmit load sets it. When both occur in the same cycle, txe is 0 afterwards.
- R3: A received data word (eng_rx_done=1, eng_rx_last=0) is stored in rx_buf and sets rxne when the buffer is empty or is read in the same cycle. A data read with no incoming word clears rxne. The store-with-read case leaves ovr unchanged.
- R4: A data word that arrives while rxne is 1 and no data read occurs sets ovr. rx_buf and rxne stay unchanged.
- R5: busy follows eng_active one cycle later and never contributes to irq.
- R6: With mst_mode=1, hardware slave-select (nss_soft_sel=0) and nss_out_drv=0, a low nss_pin sets mfault on the next edge. The same edge clears spi_en and mst_mode. With nss_out_drv=1 a low pin has no effect.
- R7: With nss_soft_sel=1, mfault is set while mst_mode=1 and nss_soft_lvl=0. nss_pin is ignored in this mode.
- R8: mfault never rises while mst_mode is 0.
- R9: While mfault is 1 and no status access (stat_rd or stat_wr) has occurred since the fault, a control write leaves spi_en and mst_mode unchanged. A status access in the same cycle as the control write does not count for that write.
- R10: After a status access, the next control write clears mfault and loads spi_en and mst_mode from the written bits. If the fault condition then still holds, mfault is set again one cycle later.
- R11: A word with eng_rx_last=1 is a CRC word. It is not stored and leaves rxne unchanged. When crc_en=1 and it differs from eng_crc_calc, crcerr is set. A match, or crc_en=0, leaves crcerr unchanged.
- R12: A status write with stat_ovr_wdata=0 clears ovr, and one with stat_crcerr_wdata=0 clears crcerr. Writing 1 keeps the flag. A new error event in the same cycle wins over the clear.
- R13: irq = (txe and txe_ie) or (rxne and rxne_ie) or (err_ie and (mfault or ovr or crcerr)), with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl0_wr | input | 1 | Write strobe for the first control register |
| ctl0_en_wdata | input | 1 | Enable bit value carried by the control write |
| ctl0_mst_wdata | input | 1 | Master bit value carried by the control write |
| stat_rd | input | 1 | Status register read strobe |
| stat_wr | input | 1 | Status register write strobe |
| stat_ovr_wdata | input | 1 | Overrun bit value in the status write (0 clears) |
| stat_crcerr_wdata | input | 1 | CRC error bit value in the status write (0 clears) |
| data_wr | input | 1 | Data register write strobe |
| data_rd | input | 1 | Data register read strobe |
| nss_soft_sel | input | 1 | 1 selects software slave-select |
| nss_soft_lvl | input | 1 | Software slave-select level |
| nss_out_drv | input | 1 | 1 when the slave-select pin is driven as an output |
| nss_pin | input | 1 | Slave-select pin level |
| crc_en | input | 1 | CRC check enable |
| txe_ie | input | 1 | Transmit-empty interrupt enable |
| rxne_ie | input | 1 | Receive-not-empty interrupt enable |
| err_ie | input | 1 | Shared error interrupt enable |
| eng_tx_load | input | 1 | Engine moved the transmit buffer into the shifter |
| eng_rx_done | input | 1 | Engine completed a received word |
| eng_rx_last | input | 1 | The completed word is the CRC word |
| eng_rx_word | input | DATA_W | Completed received word |
| eng_crc_calc | input | DATA_W | Locally computed receive CRC |
| eng_active | input | 1 | Engine is shifting |
| spi_en | output | 1 | Controller enable bit |
| mst_mode | output | 1 | Master mode bit |
| txe | output | 1 | Transmit buffer empty |
| rxne | output | 1 | Receive buffer not empty |
| busy | output | 1 | Transfer in progress |
| mfault | output | 1 | Mode fault flag |
| ovr | output | 1 | Receive overrun flag |
| crcerr | output | 1 | CRC mismatch flag |
| rx_buf | output | DATA_W | Receive buffer contents |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest state to reach is a fault that comes back: the clearing write must restore master mode while the slave-select condition is still active. The bench first raises the fault, then tries a locked write, then a status access in the same cycle as a control write. It then performs a proper two-step clear with the software level still low. It watches mfault drop for exactly one cycle and rise again. A later reset starts a seeded random phase that keeps the part in slave mode. That phase checks the receive, overrun, CRC and interrupt flags against a model cycle by cycle, including reads that coincide with arriving words.

// File: rtl/spi_stat_unit.sv
module spi_stat_unit #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl0_wr,
  input  logic              ctl0_en_wdata,
  input  logic              ctl0_mst_wdata,
  input  logic              stat_rd,
  input  logic              stat_wr,
  input  logic              stat_ovr_wdata,
  input  logic              stat_crcerr_wdata,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic              nss_soft_sel,
  input  logic              nss_soft_lvl,
  input  logic              nss_out_drv,
  input  logic              nss_pin,
  input  logic              crc_en,
  input  logic              txe_ie,
  input  logic              rxne_ie,
  input  logic              err_ie,
  input  logic              eng_tx_load,
  input  logic              eng_rx_done,
  input  logic              eng_rx_last,
  input  logic [DATA_W-1:0] eng_rx_word,
  input  logic [DATA_W-1:0] eng_crc_calc,
  input  logic              eng_active,
  output logic              spi_en,
  output logic              mst_mode,
  output logic              txe,
  output logic              rxne,
  output logic              busy,
  output logic              mfault,
  output logic              ovr,
  output logic              crcerr,
  output logic [DATA_W-1:0] rx_buf,
  output logic              irq
);

  logic fault_cond, armed, clr_done, ctl_accept;
  logic word_in, crc_in, store, overrun, crc_bad;

  assign fault_cond = mst_mode & (nss_soft_sel ? ~nss_soft_lvl : (~nss_out_drv & ~nss_pin));
  assign clr_done   = mfault & armed & ctl0_wr;
  assign ctl_accept = ctl0_wr & (~mfault | armed);

  assign word_in = eng_rx_done & ~eng_rx_last;
  assign crc_in  = eng_rx_done & eng_rx_last;
  assign store   = word_in & (~rxne | data_rd);
  assign overrun = word_in & rxne & ~data_rd;
  assign crc_bad = crc_in & crc_en & (eng_rx_word != eng_crc_calc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mfault   <= 1'b0;
      armed    <= 1'b0;
      spi_en   <= 1'b0;
      mst_mode <= 1'b0;
    end else if (fault_cond) begin
      mfault   <= 1'b1;
      armed    <= 1'b0;
      spi_en   <= 1'b0;
      mst_mode <= 1'b0;
    end else begin
      if (ctl_accept) begin
        spi_en   <= ctl0_en_wdata;
        mst_mode <= ctl0_mst_wdata;
      end
      if (clr_done) begin
        mfault <= 1'b0;
        armed  <= 1'b0;
      end else if (mfault && (stat_rd || stat_wr)) begin
        armed <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe    <= 1'b1;
      rxne   <= 1'b0;
      rx_buf <= '0;
      ovr    <= 1'b0;
      crcerr <= 1'b0;
      busy   <= 1'b0;
    end else begin
      if (data_wr)          txe <= 1'b0;
      else if (eng_tx_load) txe <= 1'b1;

      if (store) begin
        rxne   <= 1'b1;
        rx_buf <= eng_rx_word;
      end else if (data_rd) begin
        rxne <= 1'b0;
      end

      if (overrun)                          ovr <= 1'b1;
      else if (stat_wr && !stat_ovr_wdata)  ovr <= 1'b0;

      if (crc_bad)                             crcerr <= 1'b1;
      else if (stat_wr && !stat_crcerr_wdata)  crcerr <= 1'b0;

      busy <= eng_active;
    end
  end

  assign irq = (txe & txe_ie) | (rxne & rxne_ie) | (err_ie & (mfault | ovr | crcerr));

  a_r6_fault_drops_master: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mfault) |-> (!spi_en && !mst_mode));

  a_r8_fault_only_from_master: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mfault) |-> $past(mst_mode));

  a_r9_bits_locked: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mfault) && mfault) |-> ($stable(spi_en) && $stable(mst_mode)));

  a_r4_overrun_keeps_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    $past(eng_rx_done && !eng_rx_last && rxne && !data_rd) |-> (ovr && rxne && $stable(rx_buf)));

  a_r3_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
    $past(data_rd && !eng_rx_done) |-> !rxne);

  a_r11_crc_word_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
    $past(eng_rx_done && eng_rx_last && !data_rd) |-> ($stable(rx_buf) && $stable(rxne)));

  a_r13_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (txe || rxne || mfault || ovr || crcerr));

endmodule

// File: tb/spi_stat_unit_test.sv
`timescale 1ns/1ps
module spi_stat_unit_test;
  localparam int W = 16;

  logic clk = 0, rst_n = 0;
  logic ctl0_wr = 0, ctl0_en_wdata = 0, ctl0_mst_wdata = 0;
  logic stat_rd = 0, stat_wr = 0, stat_ovr_wdata = 0, stat_crcerr_wdata = 0;
  logic data_wr = 0, data_rd = 0;
  logic nss_soft_sel = 0, nss_soft_lvl = 1, nss_out_drv = 0, nss_pin = 1;
  logic crc_en = 0, txe_ie = 0, rxne_ie = 0, err_ie = 0;
  logic eng_tx_load = 0, eng_rx_done = 0, eng_rx_last = 0, eng_active = 0;
  logic [W-1:0] eng_rx_word = '0, eng_crc_calc = '0;
  logic spi_en, mst_mode, txe, rxne, busy, mfault, ovr, crcerr, irq;
  logic [W-1:0] rx_buf;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  spi_stat_unit #(.DATA_W(W)) uut (
    .clk, .rst_n, .ctl0_wr, .ctl0_en_wdata, .ctl0_mst_wdata, .stat_rd, .stat_wr,
    .stat_ovr_wdata, .stat_crcerr_wdata, .data_wr, .data_rd, .nss_soft_sel,
    .nss_soft_lvl, .nss_out_drv, .nss_pin, .crc_en, .txe_ie, .rxne_ie, .err_ie,
    .eng_tx_load, .eng_rx_done, .eng_rx_last, .eng_rx_word, .eng_crc_calc,
    .eng_active, .spi_en, .mst_mode, .txe, .rxne, .busy, .mfault, .ovr, .crcerr,
    .rx_buf, .irq
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    ctl0_wr = 0; stat_rd = 0; stat_wr = 0; data_wr = 0; data_rd = 0;
    eng_tx_load = 0; eng_rx_done = 0; eng_rx_last = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
  endtask

  function automatic logic exp_irq(logic t, logic r, logic f, logic o, logic c,
                                   logic ti, logic ri, logic ei);
    return (t & ti) | (r & ri) | (ei & (f | o | c));
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    do_reset();
    chk("R1 txe", txe, 1); chk("R1 rxne", rxne, 0); chk("R1 busy", busy, 0);
    chk("R1 mfault", mfault, 0); chk("R1 ovr", ovr, 0); chk("R1 crcerr", crcerr, 0);
    chk("R1 spi_en", spi_en, 0); chk("R1 mst_mode", mst_mode, 0);
    chk("R1 irq", irq, 0); chk("R1 rx_buf", rx_buf, 0);

    data_wr = 1; tick(); chk("R2 write clears", txe, 0);
    eng_tx_load = 1; tick(); chk("R2 load sets", txe, 1);
    data_wr = 1; eng_tx_load = 1; tick(); chk("R2 write wins", txe, 0);
    eng_tx_load = 1; tick(); chk("R2 reload", txe, 1);

    eng_rx_done = 1; eng_rx_word = 16'hA5A5; tick();
    chk("R3 rxne set", rxne, 1); chk("R3 stored", rx_buf, 16'hA5A5);
    data_rd = 1; tick(); chk("R3 read clears", rxne, 0);
    eng_rx_done = 1; eng_rx_word = 16'h00B1; tick();
    eng_rx_done = 1; eng_rx_word = 16'h00C3; data_rd = 1; tick();
    chk("R3 read+store rxne", rxne, 1); chk("R3 read+store buf", rx_buf, 16'h00C3);
    chk("R3 read+store no ovr", ovr, 0);

    eng_rx_done = 1; eng_rx_word = 16'h7777; tick();
    chk("R4 ovr set", ovr, 1); chk("R4 buf kept", rx_buf, 16'h00C3); chk("R4 rxne", rxne, 1);

    stat_wr = 1; stat_ovr_wdata = 1; stat_crcerr_wdata = 1; tick();
    chk("R12 write 1 keeps ovr", ovr, 1);
    stat_wr = 1; stat_ovr_wdata = 0; tick();
    chk("R12 write 0 clears ovr", ovr, 0);
    eng_rx_done = 1; eng_rx_word = 16'h1111; stat_wr = 1; stat_ovr_wdata = 0; tick();
    chk("R12 set wins over clear", ovr, 1);
    stat_wr = 1; stat_ovr_wdata = 0; data_rd = 1; tick();
    chk("R3 emptied", rxne, 0);

    crc_en = 1; eng_rx_done = 1; eng_rx_last = 1; eng_rx_word = 16'h1234; eng_crc_calc = 16'h1234; tick();
    chk("R11 match", crcerr, 0); chk("R11 crc word not stored rxne", rxne, 0);
    eng_rx_done = 1; eng_rx_last = 1; eng_crc_calc = 16'h1235; tick();
    chk("R11 mismatch", crcerr, 1); chk("R11 crc word not stored buf", rx_buf, 16'h00C3);
    stat_wr = 1; stat_ovr_wdata = 1; stat_crcerr_wdata = 0; tick();
    chk("R12 crcerr clear", crcerr, 0);
    crc_en = 0; eng_rx_done = 1; eng_rx_last = 1; tick();
    chk("R11 disabled", crcerr, 0);

    eng_active = 1; rxne_ie = 1; err_ie = 1; tick();
    chk("R5 busy rises", busy, 1); chk("R5 busy no irq", irq, 0);
    eng_active = 0; tick(); chk("R5 busy falls", busy, 0);
    txe_ie = 1; #1 chk("R13 txe irq", irq, 1);
    txe_ie = 0; #1 chk("R13 txe masked", irq, 0);

    nss_pin = 0; tick(); tick(); chk("R8 slave no fault", mfault, 0);
    nss_pin = 1; ctl0_wr = 1; ctl0_en_wdata = 1; ctl0_mst_wdata = 1; tick();
    chk("R6 master on", mst_mode, 1);
    nss_out_drv = 1; nss_pin = 0; tick(); tick();
    chk("R6 driven pin no fault", mfault, 0); chk("R6 still master", mst_mode, 1);
    nss_out_drv = 0; tick();
    chk("R6 fault", mfault, 1); chk("R6 en dropped", spi_en, 0); chk("R6 mst dropped", mst_mode, 0);
    chk("R13 err irq", irq, 1);
    nss_pin = 1;
    ctl0_wr = 1; tick();
    chk("R9 locked en", spi_en, 0); chk("R9 locked mst", mst_mode, 0); chk("R9 fault kept", mfault, 1);
    stat_rd = 1; ctl0_wr = 1; tick();
    chk("R9 same-cycle access locked", mst_mode, 0); chk("R9 same-cycle fault kept", mfault, 1);
    ctl0_wr = 1; tick();
    chk("R10 cleared", mfault, 0); chk("R10 en loaded", spi_en, 1); chk("R10 mst loaded", mst_mode, 1);

    nss_soft_sel = 1; nss_soft_lvl = 0; nss_pin = 1; tick();
    chk("R7 soft fault", mfault, 1); chk("R7 mst dropped", mst_mode, 0);
    stat_wr = 1; stat_ovr_wdata = 1; stat_crcerr_wdata = 1; tick();
    ctl0_wr = 1; tick();
    chk("R10 clear again", mfault, 0); chk("R10 master restored", mst_mode, 1);
    tick();
    chk("R10 fault returns", mfault, 1); chk("R10 master dropped again", mst_mode, 0);

    nss_soft_lvl = 1; nss_pin = 0; nss_soft_sel = 1;
    stat_rd = 1; tick();
    ctl0_wr = 1; ctl0_en_wdata = 1; ctl0_mst_wdata = 1; tick();
    tick();
    chk("R7 pin ignored", mfault, 0); chk("R7 master kept", mst_mode, 1);

    ctl0_wr = 1; ctl0_mst_wdata = 0; tick();
    do_reset();
    begin
      logic e_txe = 1, e_rxne = 0, e_ovr = 0, e_crc = 0, e_busy = 0;
      logic [W-1:0] e_buf = '0;
      int seed = 32'h5EED;
      void'($urandom(seed));
      for (int i = 0; i < 3000; i++) begin
        logic wi, ov, cb;
        data_wr = ($urandom % 4) == 0;
        data_rd = ($urandom % 3) == 0;
        eng_tx_load = ($urandom % 3) == 0;
        eng_rx_done = ($urandom % 2) == 0;
        eng_rx_last = ($urandom % 4) == 0;
        eng_rx_word = W'($urandom);
        eng_crc_calc = ($urandom % 2) ? eng_rx_word : eng_rx_word ^ W'($urandom % 3);
        crc_en = $urandom % 2;
        stat_wr = ($urandom % 5) == 0;
        stat_ovr_wdata = $urandom % 2;
        stat_crcerr_wdata = $urandom % 2;
        eng_active = $urandom % 2;
        txe_ie = $urandom % 2; rxne_ie = $urandom % 2; err_ie = $urandom % 2;
        nss_pin = $urandom % 2;
        wi = eng_rx_done & ~eng_rx_last;
        ov = wi & e_rxne & ~data_rd;
        cb = eng_rx_done & eng_rx_last & crc_en & (eng_rx_word != eng_crc_calc);
        if (data_wr) e_txe = 0; else if (eng_tx_load) e_txe = 1;
        if (ov) e_ovr = 1; else if (stat_wr && !stat_ovr_wdata) e_ovr = 0;
        if (cb) e_crc = 1; else if (stat_wr && !stat_crcerr_wdata) e_crc = 0;
        if (wi && (!e_rxne || data_rd)) begin e_rxne = 1; e_buf = eng_rx_word; end
        else if (data_rd) e_rxne = 0;
        e_busy = eng_active;
        tick();
        chk("R2 random txe", txe, e_txe);
        chk("R3 random rxne", rxne, e_rxne);
        chk("R3 random buf", rx_buf, e_buf);
        chk("R4 random ovr", ovr, e_ovr);
        chk("R11 random crcerr", crcerr, e_crc);
        chk("R5 random busy", busy, e_busy);
        chk("R8 random no fault", mfault, 0);
        chk("R13 random irq", irq, exp_irq(e_txe, e_rxne, 1'b0, e_ovr, e_crc, txe_ie, rxne_ie, err_ie));
      end
    end
    finish_run();
  end
endmodule